// File: doc/BRIEF.md
# Translation Lookaside Buffer with Permission Checking

This block caches virtual-to-physical page translations for a 48-bit virtual address space with 4 KiB pages. It is organised as 16 sets of 4 ways. Each way holds a valid bit, a tag taken from the virtual page number, a 40-bit physical frame number and three permission attributes: writable, user-accessible and no-execute. A lookup takes a virtual address, an access kind and a privilege flag. One cycle later it reports hit or miss, the physical address and a permission-fault flag.

Translations are installed through a fill port that carries the outcome of a page walk. A walk result that is present but would deny the access still becomes a normal entry. A result marked not-present is dropped. The block only reports permission faults. It never removes an entry because of one. Entries leave only through the single-page invalidate port, the full flush port or replacement. A full set gives up its least recently used way.

Top module: `tlb_perm`

## Requirements
- R1: Each lookup request sampled at a clock edge produces lk_valid_o high in the following cycle, with the result registered. lk_valid_o is low in a cycle that follows no request.
- R2: A hit returns lk_paddr_o = {stored frame number, lk_vaddr_i[11:0]}. A miss returns lk_hit_o = 0, lk_paddr_o = 0 and lk_fault_o = 0.
- R3: The access code is 2'b00 for read, 2'b01 for write and 2'b10 for execute; 2'b11 behaves as a read. On a hit, lk_fault_o is 1 exactly when one of the following holds:
  - a write targets a non-writable entry;
  - a user access (lk_user_i = 1) targets a non-user entry;
  - an execute targets a no-execute entry.
- R4: An entry whose access faults remains installed. Later lookups of that page still hit with the same frame.
- R5: A fill with fill_present_i = 0 installs nothing. It also leaves an existing entry for the same page unchanged.
- R6: A fill whose page is already cached in its set overwrites that way. The other ways of the set are not evicted.
- R7: The set index is virtual page number bits [3:0] (vaddr[15:12]).
  - A fill takes the lowest-numbered invalid way of its set.
  - When the set has no invalid way, the fill replaces the least recently used way.
  - Both lookup hits and fills mark their way most recently used.
- R8: A single-page invalidate removes that page. All other entries, including others in the same set, are kept.
- R9: A flush makes every entry invalid in one cycle.
- R10: Requests arriving in the same cycle are resolved as follows:
  - flush takes priority over invalidate;
  - an invalidate or flush drops a simultaneous fill;
  - a lookup sees the contents as they were before that cycle's updates.
- R11: After reset no entry is valid and lk_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_req_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 48 | Lookup virtual address |
| lk_acc_i | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 read |
| lk_user_i | input | 1 | Access made at user privilege |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Translation found |
| lk_paddr_o | output | 52 | Physical address |
| lk_fault_o | output | 1 | Permission fault on a hit |
| fill_i | input | 1 | Install a walk result |
| fill_vpn_i | input | 36 | Virtual page number of the walk result |
| fill_pfn_i | input | 40 | Physical frame number |
| fill_present_i | input | 1 | Walk found a present page |
| fill_wr_i | input | 1 | Page is writable |
| fill_user_i | input | 1 | Page is user-accessible |
| fill_nx_i | input | 1 | Page is no-execute |
| inv_i | input | 1 | Invalidate one page |
| inv_vpn_i | input | 36 | Page to invalidate |
| flush_i | input | 1 | Invalidate all entries |

## Verification
The hardest state to reach from the ports is a full set in which the recency order differs from the fill order. Only there does the replacement choice distinguish true least-recently-used from round-robin. The bench gets there by filling all 64 ways and then reading every way in a fixed order. It then re-reads one way of a chosen set, so the way that should be evicted is the second one filled. A fresh fill into that set must displace exactly that way. Same-cycle collisions are driven in dedicated cycles: fill with flush, fill with invalidate, and fill with a lookup of the same page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 32,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]           key_i,
  output logic [WAYS-1:0]            hit_vec_o,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = valid_i[w] && (tag_i[w] == key_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    way_o = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (hit_vec_o[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int WAYS = 4,
  localparam int AW  = $clog2(WAYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          touch_i,
  input  logic [AW-1:0] touch_way_i,
  output logic [AW-1:0] lru_way_o
);
  // age 0 = most recent, WAYS-1 = least recent; ages stay a permutation
  logic [WAYS-1:0][AW-1:0] age_q;
  logic [WAYS-1:0]         age_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WAYS; w++) age_q[w] <= AW'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (AW'(w) == touch_way_i)            age_q[w] <= '0;
        else if (age_q[w] < age_q[touch_way_i]) age_q[w] <= age_q[w] + AW'(1);
      end
    end
  end

  always_comb begin
    lru_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      age_zero[w] = (age_q[w] == '0);
      if (age_q[w] == AW'(WAYS-1)) lru_way_o = AW'(w);
    end
  end

  // R7: exactly one most-recent way per set at all times
  a_r7_single_mru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(age_zero) == 1);

  // R7: a touched way becomes most recent
  a_r7_touch_mru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> age_q[$past(touch_way_i)] == '0);
endmodule

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk
  import tlb_pkg::*;
(
  input  logic [1:0] acc_i,
  input  logic       user_i,
  input  logic       wr_ok_i,
  input  logic       user_ok_i,
  input  logic       nx_i,
  output logic       fault_o
);
  acc_e acc;
  assign acc = acc_e'(acc_i);

  always_comb begin
    fault_o = user_i && !user_ok_i;
    unique case (acc)
      ACC_WRITE: fault_o = fault_o || !wr_ok_i;
      ACC_EXEC:  fault_o = fault_o || nx_i;
      default:   ;
    endcase
  end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm #(
  parameter int VA_W   = 48,
  parameter int PAGE_W = 12,
  parameter int PFN_W  = 40,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int VPN_W = VA_W - PAGE_W,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS),
  localparam int PA_W  = PFN_W + PAGE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_req_i,
  input  logic [VA_W-1:0]  lk_vaddr_i,
  input  logic [1:0]       lk_acc_i,
  input  logic             lk_user_i,
  output logic             lk_valid_o,
  output logic             lk_hit_o,
  output logic [PA_W-1:0]  lk_paddr_o,
  output logic             lk_fault_o,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_present_i,
  input  logic             fill_wr_i,
  input  logic             fill_user_i,
  input  logic             fill_nx_i,
  input  logic             inv_i,
  input  logic [VPN_W-1:0] inv_vpn_i,
  input  logic             flush_i
);
  logic [SETS-1:0][WAYS-1:0]             valid_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][PFN_W-1:0]  pfn_q;
  logic [SETS-1:0][WAYS-1:0]             wr_q, usr_q, nx_q;

  // ---- lookup ----
  logic [IDX_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  lk_hit_vec;
  logic             lk_hit;
  logic [WAY_W-1:0] lk_way;
  logic             lk_fault;

  assign lk_set = lk_vaddr_i[PAGE_W +: IDX_W];
  assign lk_tag = lk_vaddr_i[PAGE_W+IDX_W +: TAG_W];

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid_i  (valid_q[lk_set]),
    .tag_i    (tag_q[lk_set]),
    .key_i    (lk_tag),
    .hit_vec_o(lk_hit_vec),
    .hit_o    (lk_hit),
    .way_o    (lk_way)
  );

  tlb_perm_chk u_perm (
    .acc_i    (lk_acc_i),
    .user_i   (lk_user_i),
    .wr_ok_i  (wr_q[lk_set][lk_way]),
    .user_ok_i(usr_q[lk_set][lk_way]),
    .nx_i     (nx_q[lk_set][lk_way]),
    .fault_o  (lk_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o <= 1'b0;
      lk_hit_o   <= 1'b0;
      lk_paddr_o <= '0;
      lk_fault_o <= 1'b0;
    end else begin
      lk_valid_o <= lk_req_i;
      lk_hit_o   <= lk_req_i && lk_hit;
      lk_paddr_o <= (lk_req_i && lk_hit) ?
                    {pfn_q[lk_set][lk_way], lk_vaddr_i[PAGE_W-1:0]} : '0;
      lk_fault_o <= lk_req_i && lk_hit && lk_fault;
    end
  end

  // ---- fill ----
  logic [IDX_W-1:0] fill_set;
  logic [TAG_W-1:0] fill_tag;
  logic [WAYS-1:0]  fill_hit_vec;
  logic             fill_match;
  logic [WAY_W-1:0] fill_match_way;
  logic             fill_ok;
  logic             free_found;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] fill_way;
  logic [SETS-1:0][WAY_W-1:0] lru_way;

  assign fill_set = fill_vpn_i[IDX_W-1:0];
  assign fill_tag = fill_vpn_i[IDX_W +: TAG_W];
  assign fill_ok  = fill_i && fill_present_i && !inv_i && !flush_i;

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fill_match (
    .valid_i  (valid_q[fill_set]),
    .tag_i    (tag_q[fill_set]),
    .key_i    (fill_tag),
    .hit_vec_o(fill_hit_vec),
    .hit_o    (fill_match),
    .way_o    (fill_match_way)
  );

  always_comb begin
    free_found = 1'b0;
    free_way   = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!valid_q[fill_set][w]) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
    end
    if (fill_match)      fill_way = fill_match_way;
    else if (free_found) fill_way = free_way;
    else                 fill_way = lru_way[fill_set];
  end

  // ---- invalidate ----
  logic [IDX_W-1:0] inv_set;
  logic [WAYS-1:0]  inv_hit_vec;
  logic             inv_hit;
  logic [WAY_W-1:0] inv_way;

  assign inv_set = inv_vpn_i[IDX_W-1:0];

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_inv_match (
    .valid_i  (valid_q[inv_set]),
    .tag_i    (tag_q[inv_set]),
    .key_i    (inv_vpn_i[IDX_W +: TAG_W]),
    .hit_vec_o(inv_hit_vec),
    .hit_o    (inv_hit),
    .way_o    (inv_way)
  );

  // ---- replacement state, one per set ----
  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic             touch;
    logic [WAY_W-1:0] touch_way;
    logic             fill_here;

    assign fill_here = fill_ok && (fill_set == IDX_W'(s));
    assign touch     = fill_here || (lk_req_i && lk_hit && (lk_set == IDX_W'(s)));
    assign touch_way = fill_here ? fill_way : lk_way;

    tlb_lru #(.WAYS(WAYS)) u_lru (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .touch_i    (touch),
      .touch_way_i(touch_way),
      .lru_way_o  (lru_way[s])
    );
  end

  // ---- storage ----
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (inv_i) begin
      if (inv_hit) valid_q[inv_set] <= valid_q[inv_set] & ~inv_hit_vec;
    end else if (fill_ok) begin
      valid_q[fill_set][fill_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_ok) begin
      tag_q[fill_set][fill_way] <= fill_tag;
      pfn_q[fill_set][fill_way] <= fill_pfn_i;
      wr_q[fill_set][fill_way]  <= fill_wr_i;
      usr_q[fill_set][fill_way] <= fill_user_i;
      nx_q[fill_set][fill_way]  <= fill_nx_i;
    end
  end

  // ---- assertions ----
  a_r1_result_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> lk_valid_o);

  a_r1_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |=> !lk_valid_o);

  a_r2_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_paddr_o[PAGE_W-1:0] == $past(lk_vaddr_i[PAGE_W-1:0]));

  a_r3_fault_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> lk_hit_o);

  a_r5_absent_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !fill_present_i && !inv_i && !flush_i) |=> $stable(valid_q));

  a_r6_no_duplicate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> $countones(fill_hit_vec) <= 1);

  a_r8_inv_removes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i && inv_hit) |=> !valid_q[$past(inv_set)][$past(inv_way)]);

  a_r9_flush_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> valid_q == '0);
endmodule

// File: tb/sim_tlb_perm.sv
module sim_tlb_perm;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [47:0] lk_vaddr = '0;
  logic [1:0]  lk_acc = '0;
  logic        lk_user = 1'b0;
  logic        lk_valid, lk_hit, lk_fault;
  logic [51:0] lk_paddr;
  logic        fill = 1'b0;
  logic [35:0] fill_vpn = '0;
  logic [39:0] fill_pfn = '0;
  logic        fill_present = 1'b0, fill_wr = 1'b0, fill_user = 1'b0, fill_nx = 1'b0;
  logic        inv = 1'b0;
  logic [35:0] inv_vpn = '0;
  logic        flush = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic        r_valid, r_hit, r_fault;
  logic [51:0] r_pa;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_perm u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_req_i(lk_req), .lk_vaddr_i(lk_vaddr), .lk_acc_i(lk_acc), .lk_user_i(lk_user),
    .lk_valid_o(lk_valid), .lk_hit_o(lk_hit), .lk_paddr_o(lk_paddr), .lk_fault_o(lk_fault),
    .fill_i(fill), .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn), .fill_present_i(fill_present),
    .fill_wr_i(fill_wr), .fill_user_i(fill_user), .fill_nx_i(fill_nx),
    .inv_i(inv), .inv_vpn_i(inv_vpn), .flush_i(flush)
  );

  function automatic logic [35:0] mkv(int s, int t);
    return {32'(t), 4'(s)};
  endfunction

  function automatic logic [39:0] pfn_of(int s, int w);
    return {8'h5A, 28'(s * 16 + w), 4'(w)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
    r_valid = lk_valid; r_hit = lk_hit; r_fault = lk_fault; r_pa = lk_paddr;
    lk_req = 1'b0; fill = 1'b0; inv = 1'b0; flush = 1'b0;
  endtask

  task automatic set_lk(input logic [35:0] vpn, input int off, input int acc, input bit usr);
    lk_req = 1'b1; lk_vaddr = {vpn, 12'(off)}; lk_acc = 2'(acc); lk_user = usr;
  endtask

  task automatic set_fill(input logic [35:0] vpn, input logic [39:0] pfn, input bit pres,
                          input bit wr, input bit usr, input bit nx);
    fill = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_present = pres;
    fill_wr = wr; fill_user = usr; fill_nx = nx;
  endtask

  task automatic do_lk(input logic [35:0] vpn, input int off, input int acc, input bit usr);
    @(negedge clk); set_lk(vpn, off, acc, usr); after_edge();
  endtask

  task automatic do_fill(input logic [35:0] vpn, input logic [39:0] pfn, input bit pres,
                         input bit wr, input bit usr, input bit nx);
    @(negedge clk); set_fill(vpn, pfn, pres, wr, usr, nx); after_edge();
  endtask

  task automatic exp_hit(input logic [35:0] vpn, input int off, input logic [39:0] pfn, input string req);
    do_lk(vpn, off, 0, 1'b0);
    chk(r_valid && r_hit && !r_fault && r_pa == {pfn, 12'(off)}, req,
        {r_valid, r_hit, r_fault, 9'd0, r_pa}, {3'b110, 9'd0, pfn, 12'(off)});
  endtask

  task automatic exp_miss(input logic [35:0] vpn, input string req);
    do_lk(vpn, 5, 1, 1'b1);
    chk(r_valid && !r_hit && !r_fault && r_pa == '0, req,
        {r_valid, r_hit, r_fault, 9'd0, r_pa}, {3'b100, 61'd0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(lk_valid == 1'b0, "R11 valid low in reset", 64'(lk_valid), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    after_edge();
    chk(r_valid == 1'b0, "R1/R11 no request no valid", 64'(r_valid), 64'd0);
    exp_miss(mkv(0, 100), "R11 empty after reset");

    // R7 R2: fill every way of every set, then read all back
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++)
        do_fill(mkv(s, 100 + w), pfn_of(s, w), 1'b1, 1'b1, 1'b1, 1'b0);
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++)
        exp_hit(mkv(s, 100 + w), (s * 37 + w * 11) % 4096, pfn_of(s, w), "R2/R7 capacity sweep");

    // R7: recency order in set 5 is now w0 < w1 < w2 < w3; touch w0 so w1 is oldest
    exp_hit(mkv(5, 100), 1, pfn_of(5, 0), "R7 touch");
    do_fill(mkv(5, 200), 40'hABCDE, 1'b1, 1'b1, 1'b1, 1'b0);
    exp_miss(mkv(5, 101), "R7 lru victim evicted");
    exp_hit(mkv(5, 100), 2, pfn_of(5, 0), "R7 recent kept");
    exp_hit(mkv(5, 102), 3, pfn_of(5, 2), "R7 kept");
    exp_hit(mkv(5, 103), 4, pfn_of(5, 3), "R7 kept");
    exp_hit(mkv(5, 200), 6, 40'hABCDE, "R7 new entry");

    // R8
    @(negedge clk); inv = 1'b1; inv_vpn = mkv(9, 102); after_edge();
    exp_miss(mkv(9, 102), "R8 page removed");
    exp_hit(mkv(9, 100), 7, pfn_of(9, 0), "R8 same set kept");
    exp_hit(mkv(9, 103), 8, pfn_of(9, 3), "R8 same set kept");
    exp_hit(mkv(8, 102), 9, pfn_of(8, 2), "R8 other set kept");

    // R6
    do_fill(mkv(10, 101), 40'h12345, 1'b1, 1'b1, 1'b1, 1'b0);
    exp_hit(mkv(10, 101), 10, 40'h12345, "R6 overwritten");
    for (int w = 0; w < 4; w++)
      if (w != 1) exp_hit(mkv(10, 100 + w), 11, pfn_of(10, w), "R6 no eviction");

    // R5
    do_fill(mkv(11, 300), 40'h777, 1'b0, 1'b1, 1'b1, 1'b0);
    exp_miss(mkv(11, 300), "R5 absent not installed");
    do_fill(mkv(11, 100), 40'h888, 1'b0, 1'b1, 1'b1, 1'b0);
    exp_hit(mkv(11, 100), 12, pfn_of(11, 0), "R5 existing unchanged");

    // R9
    @(negedge clk); flush = 1'b1; after_edge();
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++)
        exp_miss(mkv(s, 100 + w), "R9 flushed");

    // R3: permission attributes p = {nx, user, wr} in set p
    for (int p = 0; p < 8; p++)
      do_fill(mkv(p, 500), 40'(p + 64), 1'b1, p[0], p[1], p[2]);
    for (int p = 0; p < 8; p++)
      for (int acc = 0; acc < 4; acc++)
        for (int u = 0; u < 2; u++) begin
          bit ef;
          ef = (acc == 1 && !p[0]) || (u == 1 && !p[1]) || (acc == 2 && p[2]);
          do_lk(mkv(p, 500), 33, acc, u[0]);
          chk(r_hit && r_fault == ef && r_pa == {40'(p + 64), 12'd33}, "R3 fault rule",
              {r_hit, r_fault, 10'd0, r_pa}, {1'b1, ef, 10'd0, 40'(p + 64), 12'd33});
        end

    // R4: faulting entry stays
    do_lk(mkv(0, 500), 1, 1, 1'b1);
    chk(r_hit && r_fault, "R4 faulting access", {r_hit, r_fault}, 2'b11);
    do_lk(mkv(0, 500), 2, 0, 1'b0);
    chk(r_hit && !r_fault && r_pa == {40'd64, 12'd2}, "R4 entry kept after fault",
        {r_hit, r_fault, 10'd0, r_pa}, {2'b10, 10'd0, 40'd64, 12'd2});

    // R10: fill with lookup of same page in one cycle
    @(negedge clk);
    set_fill(mkv(12, 800), 40'h800, 1'b1, 1'b1, 1'b1, 1'b0);
    set_lk(mkv(12, 800), 0, 0, 1'b0);
    after_edge();
    chk(r_valid && !r_hit, "R10 lookup sees old state", {r_valid, r_hit}, 2'b10);
    exp_hit(mkv(12, 800), 13, 40'h800, "R10 fill visible next cycle");

    // R10: fill with invalidate
    do_fill(mkv(14, 701), 40'h701, 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    set_fill(mkv(15, 702), 40'h702, 1'b1, 1'b1, 1'b1, 1'b0);
    inv = 1'b1; inv_vpn = mkv(14, 701);
    after_edge();
    exp_miss(mkv(14, 701), "R10 invalidate applied");
    exp_miss(mkv(15, 702), "R10 fill dropped by invalidate");

    // R10: fill with flush, flush over invalidate
    @(negedge clk);
    set_fill(mkv(13, 601), 40'h601, 1'b1, 1'b1, 1'b1, 1'b0);
    flush = 1'b1; inv = 1'b1; inv_vpn = mkv(12, 800);
    after_edge();
    exp_miss(mkv(13, 601), "R10 fill dropped by flush");
    exp_miss(mkv(1, 500), "R10 flush applied");
    exp_miss(mkv(12, 800), "R10 flush applied");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule